// File: doc/BRIEF.md
# Instruction Line Fetch Unit with Retry

This block sits at the front of an instruction fetch pipeline that runs several hardware threads. Each thread has one buffered cache line. When a thread fetches at some program counter, the block clears the offset bits to form the line address. If that thread's buffer is valid and holds that line, the block reports a hit and the line data is available at once. If not, the block sends a line-sized read to the instruction memory port.

The port may refuse a read. A refused read is parked in a single retry slot that all threads share. The whole port then stays blocked until the memory side signals a retry. Squashes can cancel reads that are still in flight. To handle this, every read carries a small sequence tag, and a returning response fills the buffer only when its thread is still waiting and the tag matches that thread's live read. Any other response is dropped and flagged.

Top module: `line_fetch_unit`

## Requirements
- R1: The request address is the fetch PC with its low log2(LINE_BYTES) bits forced to zero. A resent request carries the address, thread and tag it was first issued with.
- R2: `lineHit` is high when the selected thread's buffer is valid and holds the aligned line. A fetch that hits issues no request.
- R3: Reset clears every valid flag. A new request clears the requesting thread's valid flag in the next cycle. An accepted response sets it in the next cycle.
- R4: A new request is issued only for a thread that has no read pending or parked, and only while the port is not blocked. A refused new request (`memReqValid` high with `memReqReady` low) sets `cacheBlocked` and parks the request in the retry slot.
- R5: When `memRetry` arrives while blocked and the slot holds a request, that request is presented again. If it is accepted, blocking ends and the thread waits for its response. If it is refused again, blocking stays.
- R6: When `memRetry` arrives while blocked and a squash has emptied the slot, blocking ends and no request is presented.
- R7: A response is accepted only when its thread is waiting for a response and its tag equals that thread's live tag. Otherwise `rspDropped` pulses and no buffer changes.
- R8: A squash returns the thread to the running state, cancels its live read and empties the retry slot if the slot belongs to that thread. A squash wins over a response or a new fetch for the same thread in the same cycle.
- R9: While `intPending` is high, no new request is issued for a fetch PC whose two low bits are 00. Fetch PCs with other low bits are not held off.
- R10: Each new request takes the current value of a shared tag counter, which starts at 0 after reset and steps by one for each new request, wrapping modulo 2^REQ_TAG_W. A resend does not step the counter.
- R11: `lineData` shows the buffered line of the thread selected by `fetchThread`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetchReq | input | 1 | A fetch is attempted this cycle |
| fetchThread | input | THR_W | Thread of the fetch attempt |
| fetchPc | input | ADDR_W | Fetch program counter |
| intPending | input | 1 | Interrupt pending; holds off line requests at PCs whose two low bits are 00 |
| squashValid | input | 1 | Squash strobe |
| squashThread | input | THR_W | Thread being squashed |
| memReqValid | output | 1 | Line read presented to memory |
| memReqAddr | output | ADDR_W | Line-aligned read address |
| memReqThread | output | THR_W | Thread that owns the read |
| memReqTag | output | REQ_TAG_W | Sequence tag of the read |
| memReqReady | input | 1 | Memory accepts the presented read |
| memRetry | input | 1 | Memory can now take a refused read |
| rspValid | input | 1 | Response strobe |
| rspThread | input | THR_W | Thread of the response |
| rspTag | input | REQ_TAG_W | Tag of the response |
| rspData | input | DATA_W | Line data of the response |
| lineHit | output | 1 | Fetch hits the thread's buffered line |
| lineData | output | DATA_W | Buffered line of the selected thread |
| lineValid | output | NUM_THREADS | Per-thread buffer valid flags |
| cacheBlocked | output | 1 | Port blocked by a parked request |
| rspDropped | output | 1 | Response discarded this cycle |

## Verification
The bench checks clean miss-then-fill sequences against repeat fetches in the same line. This separates the hit path from the request path, and shows that each thread's buffer is kept apart from the others. Refusal sequences follow a read through refusal, a second refusal and a final acceptance. They show that the blocked state keeps other threads out and that the resend reuses the original tag. Responses with a wrong tag, for an idle thread, after a squash, or in the same cycle as a squash all test the stale-response filter. A request that is refused and then squashed before the retry tests the path where only the blocked state is cleared. Interrupt-pending fetches at PCs with zero and non-zero low bits test the hold-off rule.

// File: rtl/lf_pkg.sv
package lf_pkg;

  // Per-thread fetch progress
  typedef enum logic [1:0] {
    TS_RUN       = 2'd0,
    TS_WAIT_RTRY = 2'd1,
    TS_WAIT_RSP  = 2'd2
  } thrState_e;

  // Strobes from control to the line-buffer datapath
  typedef struct packed {
    logic issue;  // new line request: retag buffer, drop valid
    logic fill;   // accepted response: write data, set valid
  } lfStrobe_t;

endpackage

// File: rtl/lf_ctrl.sv
module lf_ctrl
  import lf_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 16,
  parameter int REQ_TAG_W   = 3,
  localparam int THR_W      = $clog2(NUM_THREADS),
  localparam int OFF_W      = $clog2(LINE_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fetchReq,
  input  logic [THR_W-1:0]     fetchThread,
  input  logic [ADDR_W-1:0]    fetchPc,
  input  logic                 intPending,
  input  logic                 squashValid,
  input  logic [THR_W-1:0]     squashThread,
  input  logic                 lineHit,
  input  logic                 memReqReady,
  input  logic                 memRetry,
  input  logic                 rspValid,
  input  logic [THR_W-1:0]     rspThread,
  input  logic [REQ_TAG_W-1:0] rspTag,
  output logic                 memReqValid,
  output logic [ADDR_W-1:0]    memReqAddr,
  output logic [THR_W-1:0]     memReqThread,
  output logic [REQ_TAG_W-1:0] memReqTag,
  output logic                 cacheBlocked,
  output logic                 rspDropped,
  output lfStrobe_t            strobe,
  output logic [THR_W-1:0]     issueThread,
  output logic [ADDR_W-1:0]    issueAddr,
  output logic [THR_W-1:0]     fillThread
);

  thrState_e             thrState [NUM_THREADS];
  logic [REQ_TAG_W-1:0]  liveTag  [NUM_THREADS];
  logic [REQ_TAG_W-1:0]  tagCnt;

  // Shared retry slot
  logic                  slotFull;
  logic [ADDR_W-1:0]     slotAddr;
  logic [THR_W-1:0]      slotThread;
  logic [REQ_TAG_W-1:0]  slotTag;

  logic [ADDR_W-1:0]     alignedPc;
  logic                  slotLive;
  logic                  resend;
  logic                  resendOk;
  logic                  newIssue;
  logic                  holdInt;
  logic                  rspAccept;
  logic                  squashFetchThr;
  logic                  squashRspThr;

  assign alignedPc      = {fetchPc[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign squashFetchThr = squashValid && (squashThread == fetchThread);
  assign squashRspThr   = squashValid && (squashThread == rspThread);
  assign slotLive       = slotFull && !(squashValid && squashThread == slotThread);
  assign resend         = memRetry && cacheBlocked && slotLive;
  assign resendOk       = resend && memReqReady;
  assign holdInt        = intPending && (fetchPc[1:0] == 2'b00);

  assign newIssue = fetchReq && !lineHit && !cacheBlocked && !holdInt &&
                    (thrState[fetchThread] == TS_RUN) && !squashFetchThr;

  assign rspAccept = rspValid && (thrState[rspThread] == TS_WAIT_RSP) &&
                     (rspTag == liveTag[rspThread]) && !squashRspThr;
  assign rspDropped = rspValid && !rspAccept;

  // Port side: the resend and a new issue never coincide (issue needs !blocked)
  assign memReqValid  = resend || newIssue;
  assign memReqAddr   = resend ? slotAddr   : alignedPc;
  assign memReqThread = resend ? slotThread : fetchThread;
  assign memReqTag    = resend ? slotTag    : tagCnt;

  assign strobe.issue = newIssue;
  assign strobe.fill  = rspAccept;
  assign issueThread  = fetchThread;
  assign issueAddr    = alignedPc;
  assign fillThread   = rspThread;

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_thr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        thrState[g] <= TS_RUN;
        liveTag[g]  <= '0;
      end else if (squashValid && squashThread == THR_W'(g)) begin
        thrState[g] <= TS_RUN;
      end else if (rspAccept && rspThread == THR_W'(g)) begin
        thrState[g] <= TS_RUN;
      end else if (resendOk && slotThread == THR_W'(g)) begin
        thrState[g] <= TS_WAIT_RSP;
      end else if (newIssue && fetchThread == THR_W'(g)) begin
        thrState[g] <= memReqReady ? TS_WAIT_RSP : TS_WAIT_RTRY;
        liveTag[g]  <= tagCnt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cacheBlocked <= 1'b0;
      slotFull     <= 1'b0;
      slotAddr     <= '0;
      slotThread   <= '0;
      slotTag      <= '0;
      tagCnt       <= '0;
    end else begin
      if (newIssue) begin
        tagCnt <= tagCnt + 1'b1;
      end
      if (newIssue && !memReqReady) begin
        cacheBlocked <= 1'b1;
        slotFull     <= 1'b1;
        slotAddr     <= alignedPc;
        slotThread   <= fetchThread;
        slotTag      <= tagCnt;
      end else if (resendOk) begin
        cacheBlocked <= 1'b0;
        slotFull     <= 1'b0;
      end else begin
        if (memRetry && cacheBlocked && !slotLive) begin
          cacheBlocked <= 1'b0;
        end
        if (!slotLive) begin
          slotFull <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/lf_dpath.sv
module lf_dpath
  import lf_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 16,
  localparam int THR_W      = $clog2(NUM_THREADS),
  localparam int OFF_W      = $clog2(LINE_BYTES),
  localparam int DATA_W     = LINE_BYTES * 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [THR_W-1:0]       fetchThread,
  input  logic [ADDR_W-1:0]      fetchPc,
  input  lfStrobe_t              strobe,
  input  logic [THR_W-1:0]       issueThread,
  input  logic [ADDR_W-1:0]      issueAddr,
  input  logic [THR_W-1:0]       fillThread,
  input  logic [DATA_W-1:0]      fillData,
  output logic                   lineHit,
  output logic [DATA_W-1:0]      lineData,
  output logic [NUM_THREADS-1:0] lineValid
);

  logic [ADDR_W-1:0] lineTag [NUM_THREADS];
  logic [DATA_W-1:0] lineBuf [NUM_THREADS];
  logic              lineVld [NUM_THREADS];
  logic [ADDR_W-1:0] alignedPc;

  assign alignedPc = {fetchPc[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lineTag[g] <= '0;
        lineBuf[g] <= '0;
        lineVld[g] <= 1'b0;
      end else if (strobe.issue && issueThread == THR_W'(g)) begin
        lineTag[g] <= issueAddr;
        lineVld[g] <= 1'b0;
      end else if (strobe.fill && fillThread == THR_W'(g)) begin
        lineBuf[g] <= fillData;
        lineVld[g] <= 1'b1;
      end
    end
    assign lineValid[g] = lineVld[g];
  end

  assign lineHit  = lineVld[fetchThread] && (lineTag[fetchThread] == alignedPc);
  assign lineData = lineBuf[fetchThread];

endmodule

// File: rtl/line_fetch_unit.sv
module line_fetch_unit
  import lf_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 16,
  parameter int REQ_TAG_W   = 3,
  localparam int THR_W      = $clog2(NUM_THREADS),
  localparam int DATA_W     = LINE_BYTES * 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fetchReq,
  input  logic [THR_W-1:0]       fetchThread,
  input  logic [ADDR_W-1:0]      fetchPc,
  input  logic                   intPending,
  input  logic                   squashValid,
  input  logic [THR_W-1:0]       squashThread,
  output logic                   memReqValid,
  output logic [ADDR_W-1:0]      memReqAddr,
  output logic [THR_W-1:0]       memReqThread,
  output logic [REQ_TAG_W-1:0]   memReqTag,
  input  logic                   memReqReady,
  input  logic                   memRetry,
  input  logic                   rspValid,
  input  logic [THR_W-1:0]       rspThread,
  input  logic [REQ_TAG_W-1:0]   rspTag,
  input  logic [DATA_W-1:0]      rspData,
  output logic                   lineHit,
  output logic [DATA_W-1:0]      lineData,
  output logic [NUM_THREADS-1:0] lineValid,
  output logic                   cacheBlocked,
  output logic                   rspDropped
);

  lfStrobe_t         strobe;
  logic [THR_W-1:0]  issueThread;
  logic [ADDR_W-1:0] issueAddr;
  logic [THR_W-1:0]  fillThread;

  lf_ctrl #(
    .NUM_THREADS(NUM_THREADS), .ADDR_W(ADDR_W),
    .LINE_BYTES(LINE_BYTES), .REQ_TAG_W(REQ_TAG_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .fetchReq(fetchReq), .fetchThread(fetchThread), .fetchPc(fetchPc),
    .intPending(intPending),
    .squashValid(squashValid), .squashThread(squashThread),
    .lineHit(lineHit),
    .memReqReady(memReqReady), .memRetry(memRetry),
    .rspValid(rspValid), .rspThread(rspThread), .rspTag(rspTag),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memReqThread(memReqThread), .memReqTag(memReqTag),
    .cacheBlocked(cacheBlocked), .rspDropped(rspDropped),
    .strobe(strobe), .issueThread(issueThread), .issueAddr(issueAddr),
    .fillThread(fillThread)
  );

  lf_dpath #(
    .NUM_THREADS(NUM_THREADS), .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)
  ) u_dpath (
    .clk(clk), .rst_n(rst_n),
    .fetchThread(fetchThread), .fetchPc(fetchPc),
    .strobe(strobe), .issueThread(issueThread), .issueAddr(issueAddr),
    .fillThread(fillThread), .fillData(rspData),
    .lineHit(lineHit), .lineData(lineData), .lineValid(lineValid)
  );

endmodule

// File: rtl/line_fetch_chk.sv
module line_fetch_chk #(
  parameter int NUM_THREADS = 2,
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 16,
  localparam int THR_W      = $clog2(NUM_THREADS),
  localparam int OFF_W      = $clog2(LINE_BYTES)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   fetchReq,
  input logic [THR_W-1:0]       fetchThread,
  input logic [ADDR_W-1:0]      fetchPc,
  input logic                   intPending,
  input logic                   squashValid,
  input logic                   memReqValid,
  input logic [ADDR_W-1:0]      memReqAddr,
  input logic                   memReqReady,
  input logic                   memRetry,
  input logic                   rspValid,
  input logic [THR_W-1:0]       rspThread,
  input logic                   lineHit,
  input logic [NUM_THREADS-1:0] lineValid,
  input logic                   cacheBlocked,
  input logic                   rspDropped
);

  p_addr_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid |-> (memReqAddr[OFF_W-1:0] == '0));

  p_hit_no_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetchReq && lineHit && !memRetry) |-> !memReqValid);

  p_fill_sets_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && !rspDropped && !squashValid) |=> lineValid[$past(rspThread)]);

  p_blocked_no_new_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cacheBlocked && !memRetry) |-> !memReqValid);

  p_refuse_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (memReqValid && !memReqReady) |=> cacheBlocked);

  p_retry_unblocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (memRetry && cacheBlocked && memReqValid && memReqReady) |=> !cacheBlocked);

  p_int_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (intPending && fetchPc[1:0] == 2'b00 && !cacheBlocked) |-> !memReqValid);

  // unused-in-property guard kept minimal: fetchThread used for hit context
  p_hit_thread_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lineHit |-> lineValid[fetchThread]);

endmodule

bind line_fetch_unit line_fetch_chk #(
  .NUM_THREADS(NUM_THREADS), .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)
) u_chk (.*);

// File: tb/sim_line_fetch_unit.sv
`timescale 1ns/1ps
module sim_line_fetch_unit;

  localparam int NT = 2;
  localparam int AW = 32;
  localparam int LB = 16;
  localparam int TW = 3;
  localparam int DW = LB * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fetchReq = 0;
  logic [0:0]    fetchThread = 0;
  logic [AW-1:0] fetchPc = 0;
  logic          intPending = 0;
  logic          squashValid = 0;
  logic [0:0]    squashThread = 0;
  logic          memReqValid;
  logic [AW-1:0] memReqAddr;
  logic [0:0]    memReqThread;
  logic [TW-1:0] memReqTag;
  logic          memReqReady = 1;
  logic          memRetry = 0;
  logic          rspValid = 0;
  logic [0:0]    rspThread = 0;
  logic [TW-1:0] rspTag = 0;
  logic [DW-1:0] rspData = 0;
  logic          lineHit;
  logic [DW-1:0] lineData;
  logic [NT-1:0] lineValid;
  logic          cacheBlocked;
  logic          rspDropped;

  always #2.5 clk = ~clk;

  line_fetch_unit #(.NUM_THREADS(NT), .ADDR_W(AW), .LINE_BYTES(LB), .REQ_TAG_W(TW)) u0 (.*);

  int checks = 0;
  int fails  = 0;
  string phase = "";

  // Behavioural reference state
  bit            mV [NT];
  logic [AW-1:0] mT [NT];
  logic [DW-1:0] mD [NT];
  int            mS [NT];   // 0 running, 1 parked for retry, 2 awaiting response
  logic [TW-1:0] mP [NT];
  bit            mBlk, mSlot;
  logic [AW-1:0] mSA;
  int            mST;
  logic [TW-1:0] mSG, mCnt;

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", req, phase, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int t = 0; t < NT; t++) begin
      mV[t] = 0; mT[t] = 0; mD[t] = 0; mS[t] = 0; mP[t] = 0;
    end
    mBlk = 0; mSlot = 0; mSA = 0; mST = 0; mSG = 0; mCnt = 0;
  endtask

  // Compare all outputs against the reference, then advance it one clock
  task automatic step_model();
    int ft, rt;
    logic [AW-1:0] al;
    bit eHit, live, eRes, eNew, eAcc, eDrop, sqF, sqR;
    ft = int'(fetchThread);
    rt = int'(rspThread);
    al = fetchPc & ~AW'(LB - 1);
    eHit = mV[ft] && (mT[ft] == al);
    sqF = squashValid && (int'(squashThread) == ft);
    sqR = squashValid && (int'(squashThread) == rt);
    live = mSlot && !(squashValid && int'(squashThread) == mST);
    eRes = memRetry && mBlk && live;
    eNew = fetchReq && !eHit && !mBlk && (mS[ft] == 0) &&
           !(intPending && fetchPc[1:0] == 2'b00) && !sqF;
    eAcc = rspValid && (mS[rt] == 2) && (rspTag == mP[rt]) && !sqR;
    eDrop = rspValid && !eAcc;

    chk("R4 request valid", DW'(memReqValid), DW'(eRes || eNew));
    if (eRes) begin
      chk("R1 resend address", DW'(memReqAddr), DW'(mSA));
      chk("R5 resend thread", DW'(memReqThread), DW'(mST));
      chk("R10 resend tag", DW'(memReqTag), DW'(mSG));
    end else if (eNew) begin
      chk("R1 aligned address", DW'(memReqAddr), DW'(al));
      chk("R4 request thread", DW'(memReqThread), DW'(ft));
      chk("R10 request tag", DW'(memReqTag), DW'(mCnt));
    end
    chk("R2 hit", DW'(lineHit), DW'(eHit));
    chk("R3 valid flags", DW'(lineValid), DW'({mV[1], mV[0]}));
    chk("R4 blocked", DW'(cacheBlocked), DW'(mBlk));
    chk("R7 dropped", DW'(rspDropped), DW'(eDrop));
    chk("R11 line data", lineData, mD[ft]);

    // advance
    for (int t = 0; t < NT; t++) begin
      if (squashValid && int'(squashThread) == t) mS[t] = 0;
      else if (eAcc && rt == t) mS[t] = 0;
      else if (eRes && memReqReady && mST == t) mS[t] = 2;
      else if (eNew && ft == t) begin
        mS[t] = memReqReady ? 2 : 1;
        mP[t] = mCnt;
      end
    end
    if (eNew) begin mT[ft] = al; mV[ft] = 0; end
    if (eAcc) begin mD[rt] = rspData; mV[rt] = 1; end
    if (eNew && !memReqReady) begin
      mBlk = 1; mSlot = 1; mSA = al; mST = ft; mSG = mCnt;
    end else if (eRes && memReqReady) begin
      mBlk = 0; mSlot = 0;
    end else begin
      if (memRetry && mBlk && !live) mBlk = 0;
      if (!live) mSlot = 0;
    end
    if (eNew) mCnt = mCnt + 1'b1;
  endtask

  task automatic cyc();
    @(negedge clk);
    step_model();
    @(posedge clk);
    #1;
    fetchReq = 0; rspValid = 0; squashValid = 0; memRetry = 0;
  endtask

  task automatic fetch(int thr, logic [AW-1:0] pc);
    fetchReq = 1; fetchThread = 1'(thr); fetchPc = pc; cyc();
  endtask

  task automatic respond(int thr, int tag, logic [DW-1:0] d);
    rspValid = 1; rspThread = 1'(thr); rspTag = TW'(tag); rspData = d; cyc();
  endtask

  function automatic logic [DW-1:0] pat(int s);
    return {4{32'hC0DE_0000 + 32'(s)}};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    phase = "R3 reset state";
    cyc(); cyc();

    phase = "R1 R10 first miss";
    fetch(0, 32'h104);
    respond(0, 0, pat(1));
    phase = "R2 hit in same line";
    fetch(0, 32'h10C);
    phase = "R11 per-thread buffers";
    fetch(1, 32'h100);
    respond(1, 1, pat(2));
    fetch(0, 32'h100);
    fetch(1, 32'h108);

    phase = "R9 interrupt holdoff";
    intPending = 1;
    fetch(0, 32'h200);
    fetch(0, 32'h202);
    intPending = 0;
    respond(0, 2, pat(3));

    phase = "R4 refusal blocks port";
    memReqReady = 0;
    fetch(1, 32'h300);
    memReqReady = 1;
    fetch(0, 32'h400);
    phase = "R5 retry refused then accepted";
    memReqReady = 0; memRetry = 1; cyc();
    memReqReady = 1; memRetry = 1; cyc();
    respond(1, 3, pat(4));

    phase = "R7 response filter";
    fetch(0, 32'h500);
    respond(0, 5, pat(5));
    respond(1, 4, pat(6));
    respond(0, 4, pat(7));

    phase = "R8 squash cancels read";
    fetch(0, 32'h600);
    squashValid = 1; squashThread = 0; cyc();
    respond(0, 5, pat(8));
    fetch(0, 32'h600);
    respond(0, 6, pat(9));
    phase = "R8 squash wins over response";
    fetch(1, 32'h700);
    squashValid = 1; squashThread = 1;
    rspValid = 1; rspThread = 1; rspTag = 7; rspData = pat(10); cyc();

    phase = "R6 emptied slot retry";
    memReqReady = 0;
    fetch(0, 32'h800);
    memReqReady = 1;
    squashValid = 1; squashThread = 0; cyc();
    memRetry = 1; cyc();
    fetch(1, 32'h900);
    respond(1, 1, pat(11));
    fetch(1, 32'h904);
    cyc();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule